// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Byte Receiver

This block sits on the host side of a byte-wide parallel link and pulls bytes from a peripheral over an interlocked two-wire handshake. The peripheral owns a strobe line that idles high and drops when a byte is on the bus. The host owns an acknowledge line that idles low, rises to accept the byte and falls again to finish the transfer. Both the strobe and the eight data lines are asynchronous to the host clock. The block passes them through a parameterised synchronizer chain, detects the strobe's falling edge and waits a fixed number of settle cycles. It then latches the bus and hands the byte to a one-entry valid/ready output register.

The acknowledge is the flow-control lever. It rises only when the output register can take the byte. After the peripheral has returned its strobe high, the acknowledge stays high until the downstream consumer has taken the byte. Because the peripheral cannot begin another byte until the acknowledge is low, it is paced one byte at a time by the consumer. If a peripheral never releases its strobe after being acknowledged, a timeout drops the acknowledge and raises an error flag. The flag holds until the next strobe falling edge begins a fresh transfer.

Top module: `prx_reverse_rx`

## Requirements
- R1: While reset is asserted and right after it, host_ack_o, out_valid_o and timeout_err_o are all 0.
- R2: While periph_strobe_i stays high (its idle level), host_ack_o stays 0 and no byte is produced.
- R3: Suppose the output register is empty and periph_strobe_i falls between two clock edges. host_ack_o then reads 1 exactly SYNC_STAGES + SETTLE_CYC + 2 rising edges later, and 0 before that.
- R4: host_ack_o rises on the same edge that out_valid_o goes to 1. The byte on out_data_o equals the value that was on periph_data_i when the strobe fell.
- R5: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o does not change. A byte is consumed on an edge where both are 1.
- R6: After the strobe returns high, host_ack_o stays 1 while the byte is still unconsumed. It drops to 0 once the byte has been consumed.
- R7: A byte is loaded only when the output register has room. A strobe falling edge that arrives while host_ack_o is still high is ignored and produces no byte.
- R8: Suppose host_ack_o is high and the synchronized strobe stays low for TIMEOUT_CYC cycles. Then host_ack_o goes to 0 and timeout_err_o goes to 1. The flag stays 1 until the next strobe falling edge. TIMEOUT_CYC = 0 removes the timeout.
- R9: Every byte value 0 to 255 passes through unchanged, in order, with none lost or duplicated, whatever the pattern on out_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| periph_strobe_i | input | 1 | Peripheral byte strobe, asynchronous, idles high, falls when a byte is offered |
| periph_data_i | input | DATA_W | Peripheral data bus, asynchronous |
| host_ack_o | output | 1 | Host acknowledge: low = ready for a byte, high = byte accepted |
| out_data_o | output | DATA_W | Captured byte |
| out_valid_o | output | 1 | out_data_o holds a byte not yet consumed |
| out_ready_i | input | 1 | Downstream consumer can take the byte |
| timeout_err_o | output | 1 | Peripheral failed to release its strobe in time |

## Verification
The bench goes after the exact edge on which the acknowledge rises. A design with one synchronizer or settle stage too many or too few would acknowledge on the wrong edge, and could also latch a bus that has not yet settled. It holds the consumer off for long stretches and toggles the strobe in the meantime. A design that lowered the acknowledge early, or that took a strobe edge while a byte was still held, would lose or duplicate bytes or change the held data. Every byte value is swept under a free-running consumer and again under a throttled one, to catch dropped, repeated or reordered bytes. A stuck strobe checks that the timeout both releases the acknowledge and keeps the error flag set until the next transfer begins.

// File: rtl/prx_pkg.sv
package prx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_SETTLE    = 3'd1,
      ST_WAIT_ROOM = 3'd2,
      ST_ACKED     = 3'd3,
      ST_RELEASE   = 3'd4
   } prx_state_e;

endpackage

// File: rtl/prx_sync.sv
module prx_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("prx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("prx_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= RST_VAL;
      end else begin
         for (int k = STAGES - 1; k > 0; k--) chain_q[k] <= chain_q[k-1];
         chain_q[0] <= d_i;
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/prx_outreg.sv
module prx_outreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              room_o,
   output logic              held_o
);

   logic take_w;

   assign take_w = valid_o & ready_i;
   assign room_o = ~valid_o | ready_i;
   assign held_o = valid_o & ~ready_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end else if (take_w) begin
         valid_o <= 1'b0;
      end
   end

   // R5: a byte that is offered but not taken holds still
   assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

   // R7: the handshake engine loads only when there is room
   assert_load_has_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (!valid_o || ready_i));

endmodule

// File: rtl/prx_hs_fsm.sv
module prx_hs_fsm
   import prx_pkg::*;
#(
   parameter int SETTLE_CYC  = 2,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strb_s_i,
   input  logic room_i,
   input  logic held_i,
   output logic load_o,
   output logic ack_o,
   output logic err_o
);

   localparam int                SW          = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [SW-1:0]     SETTLE_LAST = SW'(SETTLE_CYC - 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("prx_hs_fsm: SETTLE_CYC must be at least 1");
   end
   if (TIMEOUT_CYC < 0) begin : g_bad_timeout
      $error("prx_hs_fsm: TIMEOUT_CYC must not be negative");
   end

   prx_state_e    state_q;
   logic [SW-1:0] settle_q;
   logic          strb_q;
   logic          fall_w;
   logic          to_hit_w;

   // falling edge of the synchronized strobe
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strb_q <= 1'b1;
      else         strb_q <= strb_s_i;
   end
   assign fall_w = strb_q & ~strb_s_i;

   // timeout variant chosen by parameter
   if (TIMEOUT_CYC > 0) begin : g_timeout
      localparam int            TW      = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
      localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYC - 1);
      logic [TW-1:0] to_q;
      logic          waiting_w;

      assign waiting_w = (state_q == ST_ACKED) && !strb_s_i;
      assign to_hit_w  = waiting_w && (to_q == TO_LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        to_q <= '0;
         else if (waiting_w) to_q <= to_q + 1'b1;
         else                to_q <= '0;
      end
   end else begin : g_no_timeout
      assign to_hit_w = 1'b0;
   end

   assign load_o = (state_q == ST_WAIT_ROOM) && room_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         settle_q <= '0;
         ack_o    <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (fall_w) begin
                  state_q  <= ST_SETTLE;
                  settle_q <= '0;
                  err_o    <= 1'b0;
               end
            end
            ST_SETTLE: begin
               if (settle_q == SETTLE_LAST) state_q  <= ST_WAIT_ROOM;
               else                         settle_q <= settle_q + 1'b1;
            end
            ST_WAIT_ROOM: begin
               if (room_i) begin
                  ack_o   <= 1'b1;
                  state_q <= ST_ACKED;
               end
            end
            ST_ACKED: begin
               if (to_hit_w) begin
                  ack_o   <= 1'b0;
                  err_o   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (strb_s_i) begin
                  state_q <= ST_RELEASE;
               end
            end
            ST_RELEASE: begin
               if (!held_i) begin
                  ack_o   <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               ack_o   <= 1'b0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   // R6: the acknowledge falls only once the byte is gone, or on a timeout
   assert_ack_drop_after_consume_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_o) |-> (err_o || !$past(held_i)));

   // R8: the error flag appears only together with a released acknowledge
   assert_err_with_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $fell(ack_o));

endmodule

// File: rtl/prx_reverse_rx.sv
module prx_reverse_rx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 2,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              periph_strobe_i,
   input  logic [DATA_W-1:0] periph_data_i,
   output logic              host_ack_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic              timeout_err_o
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("prx_reverse_rx: DATA_W must be at least 1");
   end

   logic              strb_s;
   logic [DATA_W-1:0] data_s;
   logic              load_w;
   logic              room_w;
   logic              held_w;

   prx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_strb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (periph_strobe_i),
      .q_o    (strb_s)
   );

   prx_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (periph_data_i),
      .q_o    (data_s)
   );

   prx_hs_fsm #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strb_s_i (strb_s),
      .room_i   (room_w),
      .held_i   (held_w),
      .load_o   (load_w),
      .ack_o    (host_ack_o),
      .err_o    (timeout_err_o)
   );

   prx_outreg #(.DATA_W(DATA_W)) u_outreg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_w),
      .data_i  (data_s),
      .ready_i (out_ready_i),
      .valid_o (out_valid_o),
      .data_o  (out_data_o),
      .room_o  (room_w),
      .held_o  (held_w)
   );

   // R4: acknowledge rises together with a freshly loaded byte
   assert_ack_with_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(host_ack_o) |-> out_valid_o);

   // R2: no byte appears without an acknowledged transfer
   assert_valid_needs_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_valid_o) |-> $rose(host_ack_o));

endmodule

// File: tb/prx_reverse_rx_tb_top.sv
module prx_reverse_rx_tb_top;

   localparam int DW   = 8;
   localparam int SYNC = 2;
   localparam int SETL = 2;
   localparam int TOUT = 24;
   localparam int LAT  = SYNC + SETL + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe = 1'b1;
   logic [DW-1:0] pdata = '0;
   logic          ack;
   logic [DW-1:0] odata;
   logic          ovalid;
   logic          ordy = 1'b1;
   logic          terr;

   int vecs = 0;
   int errs = 0;
   int mode = 0;
   int cyc  = 0;
   logic [DW-1:0] exp_q [0:1023];
   int exp_n = 0;
   int rx_n  = 0;
   logic          prev_held = 1'b0;
   logic [DW-1:0] prev_data = '0;

   always #5 clk = ~clk;

   prx_reverse_rx #(.DATA_W(DW), .SYNC_STAGES(SYNC), .SETTLE_CYC(SETL), .TIMEOUT_CYC(TOUT)) dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .periph_strobe_i (strobe),
      .periph_data_i   (pdata),
      .host_ack_o      (ack),
      .out_data_o      (odata),
      .out_valid_o     (ovalid),
      .out_ready_i     (ordy),
      .timeout_err_o   (terr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   // consumer: drives ready, records bytes, checks hold stability (R5, R9)
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         case (mode)
            0:       ordy = 1'b1;
            1:       ordy = (cyc % 3) != 0;
            default: ordy = 1'b0;
         endcase
         #1;
         if (rst_n) begin
            if (prev_held) begin
               chk(ovalid == 1'b1, "R5 valid held", int'(ovalid), 1);
               chk(odata == prev_data, "R5 data stable", int'(odata), int'(prev_data));
            end
            if (ovalid && ordy) begin
               chk(rx_n < exp_n, "R9 unexpected byte", rx_n, exp_n);
               if (rx_n < exp_n)
                  chk(odata == exp_q[rx_n], "R9 byte order/value", int'(odata), int'(exp_q[rx_n]));
               rx_n++;
            end
            prev_held = ovalid && !ordy;
            prev_data = odata;
         end
      end
   end

   task automatic wait_ack(input logic lvl, input int limit, input string req);
      int n = 0;
      while (ack !== lvl && n < limit) begin
         @(negedge clk); #2;
         n++;
      end
      chk(ack === lvl, req, int'(ack), int'(lvl));
   endtask

   // peripheral model: one complete byte; optionally checks R3 latency
   task automatic send_byte(input logic [DW-1:0] b, input bit check_lat);
      int n = 0;
      wait_ack(1'b0, 200, "R6 ack low before next byte");
      pdata = b;
      exp_q[exp_n] = b;
      exp_n++;
      @(negedge clk);
      strobe = 1'b0;
      while (n < 60) begin
         @(posedge clk);
         n++;
         @(negedge clk); #2;
         if (ack) break;
      end
      if (check_lat) chk(n == LAT, "R3 ack latency", n, LAT);
      else           chk(ack == 1'b1, "R4 ack raised", int'(ack), 1);
      @(negedge clk);
      strobe = 1'b1;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (rx_n != exp_n && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(rx_n == exp_n, req, rx_n, exp_n);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL R9 watchdog expired act=0 exp=1");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #2;
      chk(ack == 1'b0, "R1 ack in reset", int'(ack), 0);
      chk(ovalid == 1'b0, "R1 valid in reset", int'(ovalid), 0);
      chk(terr == 1'b0, "R1 err in reset", int'(terr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(ack == 1'b0 && ovalid == 1'b0 && terr == 1'b0, "R1 after reset", int'({ack, ovalid, terr}), 0);

      // R2: idle bus produces nothing
      for (int i = 0; i < 20; i++) begin
         pdata = DW'(i * 37);
         @(negedge clk); #2;
      end
      chk(ack == 1'b0, "R2 ack idle", int'(ack), 0);
      chk(ovalid == 1'b0, "R2 no byte idle", int'(ovalid), 0);
      chk(rx_n == 0, "R2 nothing received", rx_n, 0);

      // R3, R4: exact latency on a few values
      send_byte(8'h00, 1'b1);
      send_byte(8'hFF, 1'b1);
      send_byte(8'h96, 1'b1);
      drain("R4 directed bytes delivered");

      // R9: full sweep with free-running consumer
      mode = 0;
      for (int v = 0; v < 256; v++) send_byte(DW'(v), 1'b1);
      drain("R9 sweep free consumer");

      // R9: full sweep with throttled consumer, different order
      mode = 1;
      for (int v = 0; v < 256; v++) send_byte(DW'(255 - v) ^ 8'h5A, 1'b0);
      drain("R9 sweep throttled consumer");

      // R6, R7: consumer stalled, acknowledge held, stray strobe ignored
      mode = 2;
      send_byte(8'h81, 1'b0);
      repeat (30) @(negedge clk);
      #2;
      chk(ack == 1'b1, "R6 ack held while byte unconsumed", int'(ack), 1);
      chk(ovalid == 1'b1 && odata == 8'h81, "R5 byte held", int'(odata), 8'h81);
      pdata = 8'h42;
      strobe = 1'b0;
      repeat (10) @(negedge clk);
      strobe = 1'b1;
      repeat (10) @(negedge clk);
      #2;
      chk(ack == 1'b1, "R7 ack unchanged by stray strobe", int'(ack), 1);
      chk(odata == 8'h81, "R7 held byte not replaced", int'(odata), 8'h81);
      mode = 0;
      repeat (10) @(negedge clk);
      #2;
      chk(ack == 1'b0, "R6 ack dropped after consume", int'(ack), 0);
      chk(ovalid == 1'b0, "R7 no extra byte from stray strobe", int'(ovalid), 0);
      chk(rx_n == exp_n, "R7 byte count", rx_n, exp_n);

      // R8: peripheral never releases the strobe
      wait_ack(1'b0, 100, "R8 ack low before stuck test");
      pdata = 8'hA5;
      exp_q[exp_n] = 8'hA5;
      exp_n++;
      @(negedge clk);
      strobe = 1'b0;
      wait_ack(1'b1, 60, "R8 ack raised for stuck byte");
      repeat (TOUT + 20) @(negedge clk);
      #2;
      chk(ack == 1'b0, "R8 ack released by timeout", int'(ack), 0);
      chk(terr == 1'b1, "R8 error flag set", int'(terr), 1);
      strobe = 1'b1;
      repeat (10) @(negedge clk);
      #2;
      chk(terr == 1'b1, "R8 error flag persists", int'(terr), 1);
      send_byte(8'h3C, 1'b1);
      chk(terr == 1'b0, "R8 error cleared by next transfer", int'(terr), 0);
      drain("R8 bytes after timeout delivered");

      repeat (10) @(negedge clk);
      summary();
      $finish;
   end

endmodule